// File: doc/BRIEF.md
# Sticky Right Shifter for Unpacked Floating-Point Significands

This unit moves the 128-bit significand of an unpacked floating-point operand toward its least significant end by an unsigned count. Bits that leave the significand are not simply lost. The last bit to leave is kept as a round bit. Every bit that falls below that round position is ORed into a sticky bit that only ever accumulates. Operand alignment ahead of addition uses it, and so does denormalization of results that are too small.

An operand arrives as a significand, an incoming round bit, an incoming sticky bit, a class tag and an 8-bit shift count. One clock later the unit presents the shifted significand, the new round and sticky bits, and the class. A count beyond the collapse limit (113 by default) does not shift. It reduces a nonzero operand to a sticky-only value, and it retags an all-zero operand as the zero class. Exponent adjustment and the rounding decision belong to neighbouring logic.

Top module: `sticky_rshift`

## Requirements
- R1: While rst_n is low and after its release, before the first capture, the outputs read significand 0, round 0, sticky 0 and class 0.
- R2: Each set of inputs sampled at a rising clock edge appears on the outputs just after that edge, one cycle of latency, and a new operand is accepted every cycle.
- R3: A shift count of 0 reproduces the incoming significand, round bit and sticky bit unchanged.
- R4: For a count n from 1 to 113, treat V = {significand, round} as a 129-bit value. The output significand is bits 128:1 of V shifted right by n, the output round bit is bit 0 of that shifted value, and the output sticky is the incoming sticky ORed with every bit of V[n-1:0].
- R5: For a count from 1 to 113, zeros enter from the most significant end, so significand bit 127 of the output is 0.
- R6: For a count of 113 or less, a set incoming sticky bit always gives a set output sticky bit.
- R7: For a count above 113 with an all-zero significand, the class becomes 0 (zero), the significand stays zero, and round and sticky pass through unchanged.
- R8: For a count above 113 with a nonzero significand, the significand and round bit are cleared, sticky is set, and the class passes through.
- R9: For a count of 113 or less the class tag passes through unchanged. Class codes are 0 zero, 1 normal, 2 infinity, 3 quiet NaN, 4 signaling NaN.
- R10: Counts that land exactly on a 32-bit word step (32, 64, 96), counts just beside them, and the edge pair 113/114 follow R4, R7 and R8 without error.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| sig_i | input | 128 | Incoming significand |
| round_i | input | 1 | Incoming round bit |
| sticky_i | input | 1 | Incoming sticky bit |
| cls_i | input | 3 | Incoming class tag |
| shamt_i | input | 8 | Unsigned shift count |
| sig_o | output | 128 | Shifted significand, registered |
| round_o | output | 1 | Updated round bit, registered |
| sticky_o | output | 1 | Updated sticky bit, registered |
| cls_o | output | 3 | Resulting class tag, registered |

## Verification
The bench builds the unit with its defaults: four 32-bit words, an 8-bit count and a collapse limit of 113. With an 8-bit count, every value from 0 to 255 can be driven, so both sides of the collapse limit and every word and bit split of the barrel are reached in one sweep. Random significands, including sparse ones that often become zero, fill in the sticky and class corners.

// File: rtl/sticky_rshift_pkg.sv
package sticky_rshift_pkg;

    localparam int CLS_W = 3;

    typedef enum logic [CLS_W-1:0] {
        CLS_ZERO   = 3'd0,
        CLS_NORMAL = 3'd1,
        CLS_INF    = 3'd2,
        CLS_QNAN   = 3'd3,
        CLS_SNAN   = 3'd4
    } cls_e;

endpackage

// File: rtl/srs_word_stage.sv
// Coarse stage: moves the {significand, round} vector down by whole words
// and reports whether any set bit dropped off the bottom.
module srs_word_stage #(
    parameter int WORD_W    = 32,
    parameter int NUM_WORDS = 4,
    parameter int SEL_W     = 3,
    localparam int VEC_W    = WORD_W * NUM_WORDS + 1
) (
    input  logic [VEC_W-1:0] vec_i,
    input  logic [SEL_W-1:0] words_i,
    output logic [VEC_W-1:0] vec_o,
    output logic             lost_o
);

    logic [VEC_W-1:0] cand_vec  [NUM_WORDS+1];
    logic             cand_lost [NUM_WORDS+1];

    for (genvar k = 0; k <= NUM_WORDS; k++) begin : g_word
        assign cand_vec[k] = vec_i >> (k * WORD_W);
        if (k == 0) begin : g_none
            assign cand_lost[k] = 1'b0;
        end else begin : g_some
            assign cand_lost[k] = |vec_i[k*WORD_W-1:0];
        end
    end

    always_comb begin
        // Out-of-range word counts drop everything.
        vec_o  = '0;
        lost_o = |vec_i;
        for (int k = 0; k <= NUM_WORDS; k++) begin
            if (words_i == SEL_W'(k)) begin
                vec_o  = cand_vec[k];
                lost_o = cand_lost[k];
            end
        end
    end

endmodule

// File: rtl/srs_bit_stage.sv
// Fine stage: moves the vector down by 0 to WORD_W-1 bits and reports
// whether any set bit dropped off the bottom.
module srs_bit_stage #(
    parameter int WORD_W    = 32,
    parameter int VEC_W     = 129,
    localparam int BIT_W    = $clog2(WORD_W)
) (
    input  logic [VEC_W-1:0] vec_i,
    input  logic [BIT_W-1:0] bits_i,
    output logic [VEC_W-1:0] vec_o,
    output logic             lost_o
);

    logic [VEC_W-1:0] cand_vec  [WORD_W];
    logic             cand_lost [WORD_W];

    for (genvar b = 0; b < WORD_W; b++) begin : g_bit
        assign cand_vec[b] = vec_i >> b;
        if (b == 0) begin : g_none
            assign cand_lost[b] = 1'b0;
        end else begin : g_some
            assign cand_lost[b] = |vec_i[b-1:0];
        end
    end

    always_comb begin
        vec_o  = vec_i;
        lost_o = 1'b0;
        for (int b = 0; b < WORD_W; b++) begin
            if (bits_i == BIT_W'(b)) begin
                vec_o  = cand_vec[b];
                lost_o = cand_lost[b];
            end
        end
    end

endmodule

// File: rtl/srs_collapse.sv
// Final selection: normal shifted result, or the collapse outcome for an
// over-long count.
module srs_collapse #(
    parameter int SIG_W = 128
) (
    input  logic                                 over_i,
    input  logic [SIG_W-1:0]                     sig_in_i,
    input  logic                                 rnd_in_i,
    input  logic                                 stk_in_i,
    input  logic [sticky_rshift_pkg::CLS_W-1:0]  cls_in_i,
    input  logic [SIG_W-1:0]                     sig_sh_i,
    input  logic                                 rnd_sh_i,
    input  logic                                 lost_i,
    output logic [SIG_W-1:0]                     sig_o,
    output logic                                 rnd_o,
    output logic                                 stk_o,
    output logic [sticky_rshift_pkg::CLS_W-1:0]  cls_o
);
    import sticky_rshift_pkg::*;

    logic sig_nz;
    assign sig_nz = |sig_in_i;

    always_comb begin
        sig_o = sig_sh_i;
        rnd_o = rnd_sh_i;
        stk_o = stk_in_i | lost_i;
        cls_o = cls_in_i;
        if (over_i) begin
            if (sig_nz) begin
                sig_o = '0;
                rnd_o = 1'b0;
                stk_o = 1'b1;
            end else begin
                sig_o = sig_in_i;
                rnd_o = rnd_in_i;
                stk_o = stk_in_i;
                cls_o = CLS_ZERO;
            end
        end
    end

endmodule

// File: rtl/sticky_rshift.sv
module sticky_rshift #(
    parameter int WORD_W         = 32,
    parameter int NUM_WORDS      = 4,
    parameter int CNT_W          = 8,
    parameter int COLLAPSE_ABOVE = 113
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic [WORD_W*NUM_WORDS-1:0]         sig_i,
    input  logic                                round_i,
    input  logic                                sticky_i,
    input  logic [sticky_rshift_pkg::CLS_W-1:0] cls_i,
    input  logic [CNT_W-1:0]                    shamt_i,
    output logic [WORD_W*NUM_WORDS-1:0]         sig_o,
    output logic                                round_o,
    output logic                                sticky_o,
    output logic [sticky_rshift_pkg::CLS_W-1:0] cls_o
);
    import sticky_rshift_pkg::*;

    localparam int SIG_W = WORD_W * NUM_WORDS;
    localparam int VEC_W = SIG_W + 1;
    localparam int BIT_W = $clog2(WORD_W);
    localparam int SEL_W = CNT_W - BIT_W;

    typedef struct packed {
        logic [SIG_W-1:0] sig;
        logic             rnd;
        logic             stk;
        logic [CLS_W-1:0] cls;
    } res_t;

    res_t res_d, res_q;

    logic [VEC_W-1:0] vec_in, vec_mid, vec_fin;
    logic             lost_word, lost_bit;
    logic             over_limit;
    logic [SIG_W-1:0] sig_fin;
    logic             rnd_fin, stk_fin;
    logic [CLS_W-1:0] cls_fin;

    assign vec_in     = {sig_i, round_i};
    assign over_limit = shamt_i > CNT_W'(COLLAPSE_ABOVE);

    srs_word_stage #(
        .WORD_W    (WORD_W),
        .NUM_WORDS (NUM_WORDS),
        .SEL_W     (SEL_W)
    ) u_word (
        .vec_i   (vec_in),
        .words_i (shamt_i[CNT_W-1:BIT_W]),
        .vec_o   (vec_mid),
        .lost_o  (lost_word)
    );

    srs_bit_stage #(
        .WORD_W (WORD_W),
        .VEC_W  (VEC_W)
    ) u_bit (
        .vec_i  (vec_mid),
        .bits_i (shamt_i[BIT_W-1:0]),
        .vec_o  (vec_fin),
        .lost_o (lost_bit)
    );

    srs_collapse #(
        .SIG_W (SIG_W)
    ) u_collapse (
        .over_i   (over_limit),
        .sig_in_i (sig_i),
        .rnd_in_i (round_i),
        .stk_in_i (sticky_i),
        .cls_in_i (cls_i),
        .sig_sh_i (vec_fin[VEC_W-1:1]),
        .rnd_sh_i (vec_fin[0]),
        .lost_i   (lost_word | lost_bit),
        .sig_o    (sig_fin),
        .rnd_o    (rnd_fin),
        .stk_o    (stk_fin),
        .cls_o    (cls_fin)
    );

    always_comb begin
        res_d     = res_q;
        res_d.sig = sig_fin;
        res_d.rnd = rnd_fin;
        res_d.stk = stk_fin;
        res_d.cls = cls_fin;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_q <= '{sig: '0, rnd: 1'b0, stk: 1'b0, cls: CLS_ZERO};
        end else begin
            res_q <= res_d;
        end
    end

    assign sig_o    = res_q.sig;
    assign round_o  = res_q.rnd;
    assign sticky_o = res_q.stk;
    assign cls_o    = res_q.cls;

endmodule

// File: rtl/sticky_rshift_chk.sv
module sticky_rshift_chk #(
    parameter int SIG_W          = 128,
    parameter int CNT_W          = 8,
    parameter int COLLAPSE_ABOVE = 113
) (
    input logic             clk,
    input logic             rst_n,
    input logic [SIG_W-1:0] sig_i,
    input logic             round_i,
    input logic             sticky_i,
    input logic [2:0]       cls_i,
    input logic [CNT_W-1:0] shamt_i,
    input logic [SIG_W-1:0] sig_o,
    input logic             round_o,
    input logic             sticky_o,
    input logic [2:0]       cls_o
);

    logic primed_q;
    always_ff @(posedge clk) begin
        if (!rst_n) primed_q <= 1'b0;
        else        primed_q <= 1'b1;
    end

    AST_ZERO_COUNT_KEEPS: assert property (@(posedge clk) disable iff (!rst_n || !primed_q)
        $past(shamt_i) == '0 |-> (sig_o == $past(sig_i) && round_o == $past(round_i)
                                  && sticky_o == $past(sticky_i))); // R3

    AST_TOP_FILLS_ZERO: assert property (@(posedge clk) disable iff (!rst_n || !primed_q)
        ($past(shamt_i) != '0 && $past(shamt_i) <= CNT_W'(COLLAPSE_ABOVE))
            |-> !sig_o[SIG_W-1]); // R5

    AST_STICKY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n || !primed_q)
        ($past(sticky_i) && $past(shamt_i) <= CNT_W'(COLLAPSE_ABOVE)) |-> sticky_o); // R6

    AST_COLLAPSE_ZERO: assert property (@(posedge clk) disable iff (!rst_n || !primed_q)
        ($past(shamt_i) > CNT_W'(COLLAPSE_ABOVE) && $past(sig_i) == '0)
            |-> (cls_o == 3'd0 && sig_o == '0 && round_o == $past(round_i)
                 && sticky_o == $past(sticky_i))); // R7

    AST_COLLAPSE_STICKY: assert property (@(posedge clk) disable iff (!rst_n || !primed_q)
        ($past(shamt_i) > CNT_W'(COLLAPSE_ABOVE) && $past(sig_i) != '0)
            |-> (sig_o == '0 && !round_o && sticky_o && cls_o == $past(cls_i))); // R8

    AST_CLASS_PASSES: assert property (@(posedge clk) disable iff (!rst_n || !primed_q)
        $past(shamt_i) <= CNT_W'(COLLAPSE_ABOVE) |-> cls_o == $past(cls_i)); // R9

endmodule

bind sticky_rshift sticky_rshift_chk #(
    .SIG_W          (SIG_W),
    .CNT_W          (CNT_W),
    .COLLAPSE_ABOVE (COLLAPSE_ABOVE)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .sig_i    (sig_i),
    .round_i  (round_i),
    .sticky_i (sticky_i),
    .cls_i    (cls_i),
    .shamt_i  (shamt_i),
    .sig_o    (sig_o),
    .round_o  (round_o),
    .sticky_o (sticky_o),
    .cls_o    (cls_o)
);

// File: tb/sticky_rshift_bench.sv
`timescale 1ns/1ps
module sticky_rshift_bench;
    import sticky_rshift_pkg::*;

    localparam int SIG_W = 128;
    localparam int LIMIT = 113;
    localparam int EXP_W = SIG_W + 5;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [SIG_W-1:0] sig_i = '0;
    logic             round_i = 1'b0;
    logic             sticky_i = 1'b0;
    logic [2:0]       cls_i = 3'd0;
    logic [7:0]       shamt_i = 8'd0;
    logic [SIG_W-1:0] sig_o;
    logic             round_o, sticky_o;
    logic [2:0]       cls_o;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    logic [EXP_W-1:0] exp_q [$];
    string            tag_q [$];

    always #5 clk = ~clk;

    sticky_rshift u_sticky_rshift (
        .clk(clk), .rst_n(rst_n), .sig_i(sig_i), .round_i(round_i),
        .sticky_i(sticky_i), .cls_i(cls_i), .shamt_i(shamt_i),
        .sig_o(sig_o), .round_o(round_o), .sticky_o(sticky_o), .cls_o(cls_o)
    );

    // Bit-by-bit reference: {sig, round} slides down one place per step.
    function automatic logic [EXP_W-1:0] model(logic [SIG_W-1:0] s, logic r,
                                               logic k, logic [2:0] c, int n);
        logic [SIG_W:0] v;
        if (n > LIMIT) begin
            if (s == '0) return {s, r, k, 3'd0};
            return {{SIG_W{1'b0}}, 1'b0, 1'b1, c};
        end
        v = {s, r};
        for (int i = 0; i < n; i++) begin
            k = k | v[0];
            v = v >> 1;
        end
        return {v, k, c};
    endfunction

    task automatic drive(logic [SIG_W-1:0] s, logic r, logic k, logic [2:0] c,
                         int n, string tag);
        @(negedge clk);
        sig_i = s; round_i = r; sticky_i = k; cls_i = c; shamt_i = 8'(n);
        exp_q.push_back(model(s, r, k, c, n));
        tag_q.push_back(tag);
    endtask

    function automatic logic [SIG_W-1:0] rnd_sig(int sparse);
        logic [SIG_W-1:0] s;
        for (int w = 0; w < 4; w++) s[w*32 +: 32] = $urandom;
        if (sparse == 1) s = s & {4{32'h0000_0101}} & ({SIG_W{1'b0}} | ({SIG_W{1'b1}} >> ($urandom % 128)));
        if (sparse == 2) s = '0;
        return s;
    endfunction

    // Monitor: results appear just after the edge that captured the inputs (R2).
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (exp_q.size() > 0) begin
                logic [EXP_W-1:0] e;
                logic [EXP_W-1:0] a;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                a = {sig_o, round_o, sticky_o, cls_o};
                checks++;
                if (a !== e) begin
                    errors++;
                    $display("FAIL %s: got sig=%h r=%b s=%b c=%0d expected sig=%h r=%b s=%b c=%0d",
                             t, a[EXP_W-1:5], a[4], a[3], a[2:0],
                             e[EXP_W-1:5], e[4], e[3], e[2:0]);
                end
            end
        end
    end

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: got no completion expected completion");
        finish_run();
    end

    initial begin
        sig_i = {4{32'hA5A5_5A5A}}; round_i = 1'b1; sticky_i = 1'b1;
        cls_i = 3'd2; shamt_i = 8'd7;
        repeat (3) @(posedge clk);
        #2;
        checks++;
        if ({sig_o, round_o, sticky_o, cls_o} !== '0) begin  // R1
            errors++;
            $display("FAIL R1: got sig=%h r=%b s=%b c=%0d expected all zero",
                     sig_o, round_o, sticky_o, cls_o);
        end
        @(negedge clk);
        rst_n = 1'b1;

        // Directed corners
        drive(128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210, 1'b1, 1'b0, 3'd1, 0, "R3");
        drive({1'b1, 127'b0}, 1'b0, 1'b0, 3'd1, 113, "R10");
        drive({1'b1, 127'b0}, 1'b0, 1'b0, 3'd1, 114, "R10,R8");
        drive(128'h1, 1'b0, 1'b0, 3'd1, 113, "R10,R4");
        drive(128'h0000_0001_8000_0000_0000_0000_0000_0000, 1'b1, 1'b0, 3'd1, 32, "R10");
        drive({4{32'h8000_0001}}, 1'b0, 1'b0, 3'd1, 64, "R10");
        drive({4{32'h8000_0001}}, 1'b1, 1'b0, 3'd1, 96, "R10");
        drive({4{32'h4000_0002}}, 1'b0, 1'b0, 3'd1, 31, "R10");
        drive({4{32'h4000_0002}}, 1'b0, 1'b0, 3'd1, 33, "R10");
        drive({SIG_W{1'b1}}, 1'b0, 1'b0, 3'd1, 1, "R5");
        drive('0, 1'b0, 1'b1, 3'd1, 5, "R6");
        drive(128'hF0, 1'b0, 1'b0, 3'd4, 40, "R9");
        drive('0, 1'b1, 1'b0, 3'd1, 200, "R7");
        drive(128'h1, 1'b1, 1'b0, 3'd2, 255, "R8");
        drive(128'h2, 1'b1, 1'b0, 3'd0, 1, "R4");

        // Every count with a fixed dense pattern
        for (int n = 0; n < 256; n++)
            drive(128'hDEAD_BEEF_0F0F_F0F0_1357_9BDF_2468_ACE0, n[0], 1'b0, 3'(n % 5),
                  n, n > LIMIT ? "R8" : (n == 0 ? "R3" : "R4"));

        // Back-to-back random stream, mixed density
        for (int i = 0; i < 600; i++) begin
            int n;
            int sp;
            logic [SIG_W-1:0] s;
            n  = $urandom % 256;
            sp = $urandom % 4;
            if (sp == 3) sp = 0;
            s  = rnd_sig(sp);
            drive(s, 1'($urandom), 1'($urandom), 3'($urandom % 5), n,
                  n > LIMIT ? (s == '0 ? "R2,R7" : "R2,R8") : "R2,R4,R6,R9");
        end

        @(negedge clk);
        sig_i = '0; shamt_i = '0;
        repeat (4) @(posedge clk);
        #3;
        finish_run();
    end

endmodule